// File: doc/BRIEF.md
# Port-Mapped Three-Wire Serial Bridge

This block gives a processor access to a register-based serial peripheral through three I/O port addresses. Port 00H holds a device-select byte and port 01H a peripheral register address. An access to port 02H runs one complete serial transaction on a chip-select line, a clock line and one shared data line. A write to port 02H stores its byte in the addressed peripheral register. A read from port 02H fetches that register's byte.

The data line is split into an output value, an output enable and an input, so that a pad can be tristated at the chip boundary. The bridge drives the line for the command byte. On a read it releases the line for the returned byte. The processor is held off with a wait output until the serial transaction, including a guaranteed idle time on the chip select, is over.

Top module: `tws_port_bridge`

## Requirements
- R1: After a synchronous reset, `ser_cs`, `ser_sclk`, `ser_oe` and `io_wait` are low, the device-select register reads FFH and the address register reads 00H.
- R2: Full 8-bit port decode. A write to 00H stores the device-select byte and a write to 01H stores the address byte, and a read returns either one in `io_rdata` from the cycle after the request. Accesses to any port other than 00H, 01H and 02H change nothing.
- R3: A port 02H access while the device-select register holds 00H opens exactly one transaction. It sends a command byte LSB first, with bit 0 = 1 for read and 0 for write, and bits 7:1 equal to address-register bits 6:0.
- R4: On a write, the 8 data bits follow the command byte LSB first on the same line, so the peripheral register ends up holding the written byte.
- R5: On a read, `ser_oe` drops at the 8th falling clock edge and stays low to the end. The bit on `ser_din` is sampled just before each of the falling edges 9 to 16, LSB first, and the byte appears on `io_rdata` when `io_wait` falls.
- R6: `ser_dout` changes only while `ser_sclk` is low. It never changes in a cycle where the serial clock is high.
- R7: Each serial-clock half period lasts HALF_DIV system cycles, and a transaction has exactly 16 rising clock edges. `ser_sclk` and `ser_oe` are high only while `ser_cs` is high.
- R8: `io_wait` goes high in the cycle after an accepted port 02H access that starts a transaction. It stays high for exactly 35·HALF_DIV cycles and covers every cycle in which `ser_cs` is high.
- R9: When the device-select register is not 00H, a port 02H access produces no serial activity and no wait. A read of port 02H then returns FFH.
- R10: `ser_cs` stays low for at least two half periods (one serial period) before `io_wait` falls, and so between any two transactions.
- R11: Requests made while `io_wait` is high are ignored: they change no register and start no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | One-cycle I/O request strobe |
| io_we | input | 1 | 1 = port write, 0 = port read |
| io_addr | input | IO_AW | I/O port address |
| io_wdata | input | DATA_W | Write data |
| io_rdata | output | DATA_W | Registered read data |
| io_wait | output | 1 | Holds the processor while a transaction runs |
| ser_cs | output | 1 | Peripheral chip select, active high |
| ser_sclk | output | 1 | Serial clock, idles low |
| ser_dout | output | 1 | Outgoing value for the shared data line |
| ser_oe | output | 1 | Drive enable for the shared data line |
| ser_din | input | 1 | Value seen on the shared data line |

## Verification
A wrong sequencer state shows within one half period as a chip select without `io_wait`, a clock or output enable outside the chip select, or a data change while the clock is high. A miscounted bit index corrupts the command byte the bench peripheral decodes, or the round-trip data, and this shows by the end of the same transaction. A wrong end of frame shows as a rising-edge count other than 16 or a wait length other than 35 half periods. An early output enable during the read phase is seen as line contention in the cycle after the 8th falling edge.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_HIGH,
    SQ_LOW,
    SQ_HOLD,
    SQ_GAP
  } seq_state_t;

  // Half periods of one transaction: setup, 16 high, 15 low, hold, 2 gap
  localparam int unsigned HALVES_PER_TXN = 35;

endpackage

// File: rtl/tws_half_tick.sv
module tws_half_tick #(
  parameter int unsigned HALF_DIV = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);

  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/tws_port_regs.sv
module tws_port_regs #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned IO_AW     = 8,
  parameter int unsigned PORT_SEL  = 0,
  parameter int unsigned PORT_REG  = 1,
  parameter int unsigned PORT_DATA = 2,
  parameter int unsigned SEL_CODE  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_req,
  input  logic              io_we,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              busy,
  input  logic              seq_done,
  input  logic [DATA_W-1:0] seq_rx,
  output logic [DATA_W-1:0] dev_q,
  output logic [DATA_W-1:0] reg_q,
  output logic [DATA_W-1:0] io_rdata,
  output logic              start,
  output logic              start_rd
);

  localparam logic [IO_AW-1:0]  A_SEL  = IO_AW'(PORT_SEL);
  localparam logic [IO_AW-1:0]  A_REG  = IO_AW'(PORT_REG);
  localparam logic [IO_AW-1:0]  A_DATA = IO_AW'(PORT_DATA);
  localparam logic [DATA_W-1:0] SEL_V  = DATA_W'(SEL_CODE);

  logic accept, hit_sel, hit_reg, hit_dat, selected, rd_pend_q;

  assign accept   = io_req && !busy;
  assign hit_sel  = (io_addr == A_SEL);
  assign hit_reg  = (io_addr == A_REG);
  assign hit_dat  = (io_addr == A_DATA);
  assign selected = (dev_q == SEL_V);
  assign start    = accept && hit_dat && selected;
  assign start_rd = !io_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_q     <= '1;
      reg_q     <= '0;
      io_rdata  <= '0;
      rd_pend_q <= 1'b0;
    end else begin
      if (accept && io_we && hit_sel) dev_q <= io_wdata;
      if (accept && io_we && hit_reg) reg_q <= io_wdata;
      if (accept && !io_we) begin
        if (hit_sel)                   io_rdata <= dev_q;
        else if (hit_reg)              io_rdata <= reg_q;
        else if (hit_dat && !selected) io_rdata <= '1;
      end
      if (start) begin
        rd_pend_q <= !io_we;
      end else if (seq_done) begin
        if (rd_pend_q) io_rdata <= seq_rx;
        rd_pend_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tws_sequencer.sv
module tws_sequencer
  import tws_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_rd,
  input  logic [DATA_W-2:0] cmd_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  input  logic              ser_din,
  output logic              run,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx,
  output logic              ser_cs,
  output logic              ser_sclk,
  output logic              ser_dout,
  output logic              ser_oe
);

  localparam int unsigned FRAME = 2 * DATA_W;
  localparam int unsigned IW    = $clog2(FRAME);
  localparam logic [IW-1:0] LAST_BIT  = IW'(FRAME - 1);
  localparam logic [IW-1:0] FIRST_RX  = IW'(DATA_W);
  localparam logic [IW-1:0] LAST_CMD  = IW'(DATA_W - 1);

  seq_state_t        state_q;
  logic [FRAME-1:0]  tx_q;
  logic [DATA_W-1:0] rx_q;
  logic [IW-1:0]     bit_q, nxt_bit;
  logic              rd_q, gap_q;

  assign nxt_bit = bit_q + 1'b1;
  assign run     = (state_q != SQ_IDLE);
  assign done    = (state_q == SQ_GAP) && tick && gap_q;
  assign rx      = rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SQ_IDLE;
      tx_q     <= '0;
      rx_q     <= '0;
      bit_q    <= '0;
      rd_q     <= 1'b0;
      gap_q    <= 1'b0;
      busy     <= 1'b0;
      ser_cs   <= 1'b0;
      ser_sclk <= 1'b0;
      ser_dout <= 1'b0;
      ser_oe   <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (start) begin
            tx_q     <= {wdata, cmd_addr, start_rd};
            rd_q     <= start_rd;
            bit_q    <= '0;
            busy     <= 1'b1;
            ser_cs   <= 1'b1;
            ser_sclk <= 1'b0;
            ser_oe   <= 1'b1;
            ser_dout <= start_rd;
            state_q  <= SQ_SETUP;
          end
        end
        SQ_SETUP, SQ_LOW: begin
          if (tick) begin
            ser_sclk <= 1'b1;
            state_q  <= SQ_HIGH;
          end
        end
        SQ_HIGH: begin
          if (tick) begin
            ser_sclk <= 1'b0;
            if (rd_q && bit_q >= FIRST_RX) rx_q <= {ser_din, rx_q[DATA_W-1:1]};
            if (bit_q == LAST_BIT) begin
              ser_oe   <= 1'b0;
              ser_dout <= 1'b0;
              state_q  <= SQ_HOLD;
            end else begin
              bit_q   <= nxt_bit;
              state_q <= SQ_LOW;
              if (rd_q && bit_q >= LAST_CMD) begin
                ser_oe   <= 1'b0;
                ser_dout <= 1'b0;
              end else begin
                ser_dout <= tx_q[nxt_bit];
              end
            end
          end
        end
        SQ_HOLD: begin
          if (tick) begin
            ser_cs  <= 1'b0;
            gap_q   <= 1'b0;
            state_q <= SQ_GAP;
          end
        end
        SQ_GAP: begin
          if (tick) begin
            if (gap_q) begin
              busy    <= 1'b0;
              state_q <= SQ_IDLE;
            end else begin
              gap_q <= 1'b1;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tws_port_bridge.sv
module tws_port_bridge #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned IO_AW     = 8,
  parameter int unsigned HALF_DIV  = 13,
  parameter int unsigned PORT_SEL  = 0,
  parameter int unsigned PORT_REG  = 1,
  parameter int unsigned PORT_DATA = 2,
  parameter int unsigned SEL_CODE  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_req,
  input  logic              io_we,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_wait,
  output logic              ser_cs,
  output logic              ser_sclk,
  output logic              ser_dout,
  output logic              ser_oe,
  input  logic              ser_din
);

  logic [DATA_W-1:0] dev_q, reg_q, seq_rx;
  logic              start, start_rd, run, tick, seq_done;

  tws_port_regs #(
    .DATA_W(DATA_W), .IO_AW(IO_AW), .PORT_SEL(PORT_SEL),
    .PORT_REG(PORT_REG), .PORT_DATA(PORT_DATA), .SEL_CODE(SEL_CODE)
  ) u_regs (
    .clk(clk), .rst(rst), .io_req(io_req), .io_we(io_we),
    .io_addr(io_addr), .io_wdata(io_wdata), .busy(io_wait),
    .seq_done(seq_done), .seq_rx(seq_rx), .dev_q(dev_q), .reg_q(reg_q),
    .io_rdata(io_rdata), .start(start), .start_rd(start_rd)
  );

  tws_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst(rst), .en(run), .tick(tick)
  );

  tws_sequencer #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_rd(start_rd),
    .cmd_addr(reg_q[DATA_W-2:0]), .wdata(io_wdata), .tick(tick),
    .ser_din(ser_din), .run(run), .busy(io_wait), .done(seq_done),
    .rx(seq_rx), .ser_cs(ser_cs), .ser_sclk(ser_sclk),
    .ser_dout(ser_dout), .ser_oe(ser_oe)
  );

endmodule

// File: rtl/tws_bridge_chk.sv
module tws_bridge_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned IO_AW     = 8,
  parameter int unsigned HALF_DIV  = 13,
  parameter int unsigned PORT_DATA = 2,
  parameter int unsigned SEL_CODE  = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              io_req,
  input logic [IO_AW-1:0]  io_addr,
  input logic              io_wait,
  input logic              ser_cs,
  input logic              ser_sclk,
  input logic              ser_dout,
  input logic              ser_oe,
  input logic [DATA_W-1:0] dev_q
);

  localparam int unsigned SAT = 2 * HALF_DIV;
  localparam int unsigned GW  = $clog2(SAT + 1);
  localparam logic [GW-1:0] SAT_V = GW'(SAT);

  logic [GW-1:0] low_cnt_q;
  logic          data_req, sel_ok;

  assign data_req = io_req && (io_addr == IO_AW'(PORT_DATA)) && !io_wait;
  assign sel_ok   = (dev_q == DATA_W'(SEL_CODE));

  always_ff @(posedge clk) begin
    if (rst)                  low_cnt_q <= SAT_V;
    else if (ser_cs)          low_cnt_q <= '0;
    else if (low_cnt_q != SAT_V) low_cnt_q <= low_cnt_q + 1'b1;
  end

  p_dout_steady_r6: assert property (@(posedge clk) disable iff (rst)
    ser_sclk |-> $stable(ser_dout));

  p_sclk_in_cs_r7: assert property (@(posedge clk) disable iff (rst)
    ser_sclk |-> ser_cs);

  p_oe_in_cs_r5: assert property (@(posedge clk) disable iff (rst)
    ser_oe |-> ser_cs);

  p_wait_covers_cs_r8: assert property (@(posedge clk) disable iff (rst)
    ser_cs |-> io_wait);

  p_wait_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (data_req && sel_ok) |=> (io_wait && ser_cs));

  p_unselected_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (data_req && !sel_ok) |=> (!io_wait && !ser_cs));

  p_gap_before_release_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(io_wait) |-> (low_cnt_q == SAT_V));

  p_cs_gap_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_cs) |-> (low_cnt_q == SAT_V));

endmodule

bind tws_port_bridge tws_bridge_chk #(
  .DATA_W(DATA_W), .IO_AW(IO_AW), .HALF_DIV(HALF_DIV),
  .PORT_DATA(PORT_DATA), .SEL_CODE(SEL_CODE)
) u_chk (
  .clk(clk), .rst(rst), .io_req(io_req), .io_addr(io_addr),
  .io_wait(io_wait), .ser_cs(ser_cs), .ser_sclk(ser_sclk),
  .ser_dout(ser_dout), .ser_oe(ser_oe), .dev_q(dev_q)
);

// File: tb/sim_tws_port_bridge.sv
module sim_tws_port_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;
  localparam int TXN_CYC = 35 * HALF;
  localparam int NV = 11;
  // {dev, reg, we, wdata, expected read}
  localparam logic [32:0] VEC [NV] = '{
    {8'h00, 8'h03, 1'b1, 8'hA5, 8'h00},
    {8'h00, 8'h03, 1'b0, 8'h00, 8'hA5},
    {8'h00, 8'h7E, 1'b1, 8'h3C, 8'h00},
    {8'h00, 8'h7E, 1'b0, 8'h00, 8'h3C},
    {8'h00, 8'h03, 1'b0, 8'h00, 8'hA5},
    {8'h05, 8'h03, 1'b1, 8'h00, 8'h00},
    {8'h00, 8'h03, 1'b0, 8'h00, 8'hA5},
    {8'h01, 8'h03, 1'b0, 8'h00, 8'hFF},
    {8'h00, 8'h10, 1'b1, 8'h81, 8'h00},
    {8'h00, 8'h10, 1'b0, 8'h00, 8'h81},
    {8'h00, 8'h90, 1'b0, 8'h00, 8'h81}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_req = 1'b0, io_we = 1'b0;
  logic [7:0] io_addr = '0, io_wdata = '0;
  logic [7:0] io_rdata;
  logic io_wait, ser_cs, ser_sclk, ser_dout, ser_oe;
  logic ser_din = 1'b0;

  int total = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tws_port_bridge #(.HALF_DIV(HALF)) u0 (
    .clk(clk), .rst(rst), .io_req(io_req), .io_we(io_we),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_wait(io_wait), .ser_cs(ser_cs), .ser_sclk(ser_sclk),
    .ser_dout(ser_dout), .ser_oe(ser_oe), .ser_din(ser_din)
  );

  // Peripheral model, evaluated away from the active edge
  logic [7:0] pmem [128];
  logic [4:0] pbits = '0;
  logic [7:0] pcmd = '0, pdat = '0, last_cmd = '0;
  logic prev_sclk = 0, prev_cs = 0, prev_dout = 0;
  int rises = 0, last_rises = 0, txns = 0, hi_len = 0, low_len = 0;
  int min_gap = 1000000, bad_half = 0, dout_bad = 0, cont_bad = 0;

  initial for (int i = 0; i < 128; i++) pmem[i] = 8'h00;

  always @(negedge clk) begin
    if (ser_cs && !prev_cs) begin
      if (txns > 0 && low_len < min_gap) min_gap = low_len;
      txns++;
      rises = 0;
    end
    if (!ser_cs && prev_cs) begin
      last_rises = rises;
      last_cmd = pcmd;
    end
    if (!ser_cs) begin
      pbits = '0;
      low_len++;
    end else begin
      low_len = 0;
      if (ser_sclk && !prev_sclk) begin
        if (pbits < 5'd8) pcmd[pbits[2:0]] = ser_dout;
        else if (!pcmd[0]) pdat[pbits[2:0]] = ser_dout;
        pbits = pbits + 5'd1;
        rises++;
        if (pbits == 5'd16 && !pcmd[0]) pmem[pcmd[7:1]] = pdat;
      end
      if (!ser_sclk && prev_sclk && pcmd[0] && pbits >= 5'd8 && pbits < 5'd16)
        ser_din = pmem[pcmd[7:1]][pbits[2:0]];
      if (ser_sclk && prev_sclk && ser_dout != prev_dout) dout_bad++;
      if (pcmd[0] && pbits >= 5'd8 && !ser_sclk && ser_oe) cont_bad++;
    end
    if (ser_sclk) hi_len++;
    else if (prev_sclk) begin
      if (hi_len != HALF) bad_half++;
      hi_len = 0;
    end
    prev_sclk = ser_sclk;
    prev_cs = ser_cs;
    prev_dout = ser_dout;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic io_cycle(input logic we, input logic [7:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output int wc);
    io_req = 1'b1; io_we = we; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_req = 1'b0;
    wc = 0;
    while (io_wait) begin
      @(negedge clk);
      wc++;
    end
    rd = io_rdata;
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int wc, t0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({ser_cs, ser_sclk, ser_oe, io_wait} == 4'b0, "R1 idle outputs",
        {ser_cs, ser_sclk, ser_oe, io_wait}, 0);
    io_cycle(1'b0, 8'h00, 8'h00, rd, wc);
    chk(rd == 8'hFF, "R1 select reset", rd, 8'hFF);
    io_cycle(1'b0, 8'h01, 8'h00, rd, wc);
    chk(rd == 8'h00, "R1 address reset", rd, 8'h00);

    // R2 decode
    io_cycle(1'b1, 8'h01, 8'h2A, rd, wc);
    io_cycle(1'b0, 8'h01, 8'h00, rd, wc);
    chk(rd == 8'h2A, "R2 address readback", rd, 8'h2A);
    io_cycle(1'b1, 8'h05, 8'h55, rd, wc);
    io_cycle(1'b1, 8'h81, 8'h00, rd, wc);
    io_cycle(1'b0, 8'h00, 8'h00, rd, wc);
    chk(rd == 8'hFF, "R2 foreign port kept select", rd, 8'hFF);
    io_cycle(1'b0, 8'h01, 8'h00, rd, wc);
    chk(rd == 8'h2A, "R2 foreign port kept address", rd, 8'h2A);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = VEC[i];
      io_cycle(1'b1, 8'h00, v[32:25], rd, wc);
      io_cycle(1'b1, 8'h01, v[24:17], rd, wc);
      t0 = txns;
      io_cycle(v[16], 8'h02, v[15:8], rd, wc);
      if (v[32:25] == 8'h00) begin
        chk(wc == TXN_CYC, "R8 wait length", wc, TXN_CYC);
        chk(txns == t0 + 1, "R3 one transaction", txns - t0, 1);
        chk(last_cmd == {v[23:17], ~v[16]}, "R3 command byte", last_cmd, {v[23:17], ~v[16]});
        chk(last_rises == 16, "R7 rising edges", last_rises, 16);
        if (v[16]) chk(pmem[v[23:17]] == v[15:8], "R4 written byte", pmem[v[23:17]], v[15:8]);
        else chk(rd == v[7:0], "R5 read byte", rd, v[7:0]);
      end else begin
        chk(wc == 0, "R9 no wait", wc, 0);
        chk(txns == t0, "R9 no transaction", txns - t0, 0);
        if (!v[16]) chk(rd == 8'hFF, "R9 idle read value", rd, 8'hFF);
      end
    end

    // R11 requests during wait are ignored
    io_cycle(1'b1, 8'h00, 8'h00, rd, wc);
    io_cycle(1'b1, 8'h01, 8'h05, rd, wc);
    t0 = txns;
    io_req = 1'b1; io_we = 1'b1; io_addr = 8'h02; io_wdata = 8'h5A;
    @(negedge clk);
    io_req = 1'b0;
    repeat (10) @(negedge clk);
    io_req = 1'b1; io_we = 1'b1; io_addr = 8'h01; io_wdata = 8'h77;
    @(negedge clk);
    io_addr = 8'h02; io_wdata = 8'hEE;
    @(negedge clk);
    io_req = 1'b0;
    while (io_wait) @(negedge clk);
    chk(txns == t0 + 1, "R11 no extra transaction", txns - t0, 1);
    io_cycle(1'b0, 8'h01, 8'h00, rd, wc);
    chk(rd == 8'h05, "R11 address unchanged", rd, 8'h05);
    io_cycle(1'b0, 8'h02, 8'h00, rd, wc);
    chk(rd == 8'h5A, "R11 data unchanged", rd, 8'h5A);

    // R10 back-to-back transactions
    io_cycle(1'b0, 8'h02, 8'h00, rd, wc);
    io_cycle(1'b1, 8'h02, 8'hC3, rd, wc);
    chk(min_gap >= 2 * HALF, "R10 chip select gap", min_gap, 2 * HALF);

    // Whole-run line checks
    chk(cont_bad == 0, "R5 line released on read", cont_bad, 0);
    chk(dout_bad == 0, "R6 data stable while clock high", dout_bad, 0);
    chk(bad_half == 0, "R7 half period length", bad_half, 0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule